// File: doc/BRIEF.md
# Interrupt Gate Decode and Privilege Check

This block handles one entry of the interrupt table once it has been fetched. For each request it classifies the 4-bit gate code. It flags a task switch or a malformed gate, and picks the number of bytes each stack push will use. It also works out the privilege level the handler will run at, and whether that level differs from the current one. In long mode a gate entry is 16 bytes wide, so the block reads the second 8-byte half of the entry through its own read port. It then joins the upper 32 address bits from that read to the low offset that came with the request.

The request, the table read (address and response) and the result each use a valid/ready pair. A request is taken only when `req_valid` and `req_ready` are high on the same clock edge. `req_ready` is high only while the block is idle, so the block holds one request at a time. A read address, once raised, stays valid and unchanged until `rd_req_ready` accepts it. A result stays valid and unchanged until `res_ready` takes it. The block accepts no new request before that. The task switch, descriptor validity checks and the stack switch are left to neighbouring logic.

Top module: `int_gate_check`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. If a request does not need a table read (legacy mode, task gate or bad gate), `res_valid` rises in the cycle after the request is accepted, and `rd_req_valid` stays low.
- R2: Gate code 5h is a task gate. It gives `res_task_switch`=1, `res_push_bytes`=0, `res_target`=0, `res_target_pl`=0 and `res_pl_change`=0, and no table read is made.
- R3: A gate code other than 5h, 6h, 7h, Eh or Fh gives `res_bad_gate`=1 and zero in every other result field, and no table read is made. `res_task_switch` and `res_bad_gate` are never both high.
- R4: In legacy mode (`req_long_mode`=0), codes Eh and Fh give `res_push_bytes`=4 and codes 6h and 7h give 2. The field holds the push width as a byte count, so it always has at most one bit set.
- R5: In long mode every valid non-task gate code gives `res_push_bytes`=8.
- R6: In long mode, a valid non-task gate starts a read at `rd_addr` = vector×16+8. `rd_req_valid` stays high with `rd_addr` unchanged until `rd_req_ready` is seen.
- R7: In long mode, `res_target` is {`rd_rsp_data`[31:0], `req_offset_lo`}, and `res_valid` rises in the cycle after the response handshake. In legacy mode, `res_target` is `req_offset_lo` with zeros above it.
- R8: `res_target_pl` equals `req_cpl` when `req_cs_conforming`=1, and equals `req_cs_dpl` otherwise.
- R9: `res_pl_change` is 1 exactly when `req_cpl` differs from `res_target_pl`.
- R10: While `res_valid`=1 and `res_ready`=0, all result fields hold steady and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_long_mode | input | 1 | 1 = long mode, 0 = legacy protected mode |
| req_gate_type | input | 4 | Gate type code from the table entry |
| req_offset_lo | input | 32 | Low offset held in the gate |
| req_vector | input | 8 | Interrupt vector number |
| req_cs_conforming | input | 1 | Target code segment is conforming |
| req_cs_dpl | input | 2 | Target code segment privilege level |
| req_cpl | input | 2 | Current privilege level |
| rd_req_valid | output | 1 | Table read address valid |
| rd_req_ready | input | 1 | Table read address accepted |
| rd_addr | output | 12 | Byte offset into the table, vector×16+8 |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Block waiting for read data |
| rd_rsp_data | input | 64 | 8-byte read data; bits 31:0 give the upper target address bits |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_task_switch | output | 1 | Task switch needed |
| res_bad_gate | output | 1 | Gate code not recognised |
| res_push_bytes | output | 4 | Stack push width in bytes (0, 2, 4 or 8) |
| res_target | output | 64 | Handler entry address |
| res_target_pl | output | 2 | Privilege level of the handler |
| res_pl_change | output | 1 | Privilege level changes |

## Verification
The bench aims at three things. The first is the mode split of push widths: a design that keyed on the gate code alone would report 4 instead of 8 in long mode. The second is the long-mode read, with vectors 00h and FFh at the ends of the address range, and a stalled `rd_req_ready`. A design that swapped the halves, dropped the +8, or let the address move while stalled would give the wrong target or address. The third covers task gates and unknown codes in both modes, which must give no read, zeroed fields and a one-cycle turnaround; a conforming segment must keep the current level, and a stalled `res_ready` must freeze the result and keep `req_ready` low.

// File: rtl/igc_pkg.sv
package igc_pkg;
  localparam int TYPE_W = 4;
  localparam int PUSH_W = 4;

  localparam logic [TYPE_W-1:0] GT_TASK   = 4'h5;
  localparam logic [TYPE_W-1:0] GT_INT16  = 4'h6;
  localparam logic [TYPE_W-1:0] GT_TRAP16 = 4'h7;
  localparam logic [TYPE_W-1:0] GT_INT32  = 4'hE;
  localparam logic [TYPE_W-1:0] GT_TRAP32 = 4'hF;

  typedef struct packed {
    logic              task_sw;
    logic              bad;
    logic [PUSH_W-1:0] push_bytes;
  } gate_info_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } top_state_e;
endpackage

// File: rtl/igc_gate_decode.sv
module igc_gate_decode
  import igc_pkg::*;
(
  input  logic [TYPE_W-1:0] gate_type,
  input  logic              long_mode,
  output gate_info_t        info
);
  always_comb begin
    info = '0;
    unique case (gate_type)
      GT_TASK:              info.task_sw = 1'b1;
      GT_INT32, GT_TRAP32:  info.push_bytes = long_mode ? 4'd8 : 4'd4;
      GT_INT16, GT_TRAP16:  info.push_bytes = long_mode ? 4'd8 : 4'd2;
      default:              info.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/igc_priv_check.sv
module igc_priv_check #(
  parameter int PL_W = 2
) (
  input  logic            conforming,
  input  logic [PL_W-1:0] seg_dpl,
  input  logic [PL_W-1:0] cur_pl,
  output logic [PL_W-1:0] target_pl,
  output logic            pl_change
);
  always_comb begin
    target_pl = conforming ? cur_pl : seg_dpl;
    pl_change = (target_pl != cur_pl);
  end
endmodule

// File: rtl/igc_upper_fetch.sv
module igc_upper_fetch #(
  parameter int VEC_W  = 8,
  parameter int HALF_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vector,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [VEC_W+3:0]  rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              done,
  output logic [HALF_W-1:0] upper
);
  localparam logic [3:0] HALF_SEL = 4'h8;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_state_e;
  fetch_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= F_IDLE;
      rd_addr <= '0;
    end else begin
      unique case (state)
        F_IDLE: if (start) begin
          rd_addr <= {vector, HALF_SEL};
          state   <= F_REQ;
        end
        F_REQ:  if (rd_req_ready) state <= F_WAIT;
        F_WAIT: if (rd_rsp_valid) state <= F_IDLE;
        default: state <= F_IDLE;
      endcase
    end
  end

  assign rd_req_valid = (state == F_REQ);
  assign rd_rsp_ready = (state == F_WAIT);
  assign done         = (state == F_WAIT) && rd_rsp_valid;
  assign upper        = rd_rsp_data[HALF_W-1:0];

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));
endmodule

// File: rtl/int_gate_check.sv
module int_gate_check
  import igc_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int HALF_W = 32,
  parameter int DATA_W = 64,
  parameter int PL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_long_mode,
  input  logic [TYPE_W-1:0]   req_gate_type,
  input  logic [HALF_W-1:0]   req_offset_lo,
  input  logic [VEC_W-1:0]    req_vector,
  input  logic                req_cs_conforming,
  input  logic [PL_W-1:0]     req_cs_dpl,
  input  logic [PL_W-1:0]     req_cpl,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [VEC_W+3:0]    rd_addr,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [DATA_W-1:0]   rd_rsp_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic                res_task_switch,
  output logic                res_bad_gate,
  output logic [PUSH_W-1:0]   res_push_bytes,
  output logic [2*HALF_W-1:0] res_target,
  output logic [PL_W-1:0]     res_target_pl,
  output logic                res_pl_change
);
  localparam int TGT_W = 2 * HALF_W;

  top_state_e         state;
  gate_info_t         info;
  logic [PL_W-1:0]    calc_pl;
  logic               calc_chg;
  logic               accept, gate_ok, need_fetch, fetch_done;
  logic [HALF_W-1:0]  upper_half;

  igc_gate_decode u_decode (
    .gate_type (req_gate_type),
    .long_mode (req_long_mode),
    .info      (info)
  );

  igc_priv_check #(.PL_W(PL_W)) u_priv (
    .conforming (req_cs_conforming),
    .seg_dpl    (req_cs_dpl),
    .cur_pl     (req_cpl),
    .target_pl  (calc_pl),
    .pl_change  (calc_chg)
  );

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign gate_ok    = !info.task_sw && !info.bad;
  assign need_fetch = req_long_mode && gate_ok;

  igc_upper_fetch #(.VEC_W(VEC_W), .HALF_W(HALF_W), .DATA_W(DATA_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept && need_fetch),
    .vector       (req_vector),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .rd_rsp_data  (rd_rsp_data),
    .done         (fetch_done),
    .upper        (upper_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      res_task_switch <= 1'b0;
      res_bad_gate    <= 1'b0;
      res_push_bytes  <= '0;
      res_target      <= '0;
      res_target_pl   <= '0;
      res_pl_change   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          res_task_switch <= info.task_sw;
          res_bad_gate    <= info.bad;
          res_push_bytes  <= info.push_bytes;
          res_target      <= gate_ok ? {{HALF_W{1'b0}}, req_offset_lo} : '0;
          res_target_pl   <= gate_ok ? calc_pl : '0;
          res_pl_change   <= gate_ok ? calc_chg : 1'b0;
          state           <= need_fetch ? ST_FETCH : ST_DONE;
        end
        ST_FETCH: if (fetch_done) begin
          res_target[TGT_W-1:HALF_W] <= upper_half;
          state                      <= ST_DONE;
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_valid = (state == ST_DONE);

  assert_legacy_turn_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_long_mode |=> res_valid);
  assert_legacy_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_long_mode |=> !rd_req_valid);
  assert_fault_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_task_switch && res_bad_gate));
  assert_task_nopush_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_task_switch |-> res_push_bytes == '0);
  assert_push_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_push_bytes));
  assert_rsp_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rsp_valid && rd_rsp_ready |=> res_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_target)
      && $stable(res_push_bytes) && $stable(res_target_pl));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);
endmodule

// File: tb/int_gate_check_tb.sv
module int_gate_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_long_mode = 1'b0;
  logic [3:0]  req_gate_type = '0;
  logic [31:0] req_offset_lo = '0;
  logic [7:0]  req_vector = '0;
  logic        req_cs_conforming = 1'b0;
  logic [1:0]  req_cs_dpl = '0;
  logic [1:0]  req_cpl = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [11:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [63:0] rd_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic        res_task_switch, res_bad_gate, res_pl_change;
  logic [3:0]  res_push_bytes;
  logic [63:0] res_target;
  logic [1:0]  res_target_pl;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  int_gate_check u_dut (.*);

  typedef struct packed {
    logic        lm;
    logic [3:0]  gtype;
    logic [31:0] off;
    logic [7:0]  vec;
    logic        conf;
    logic [1:0]  dpl;
    logic [1:0]  cpl;
    logic [31:0] upper;
    logic        e_task;
    logic        e_bad;
    logic [3:0]  e_push;
    logic [1:0]  e_pl;
    logic        e_chg;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'hE, 32'h1234_5678, 8'h21, 1'b0, 2'd0, 2'd3, 32'h0,         1'b0, 1'b0, 4'd4, 2'd0, 1'b1},
    '{1'b0, 4'hF, 32'hCAFE_0001, 8'h40, 1'b1, 2'd0, 2'd2, 32'h0,         1'b0, 1'b0, 4'd4, 2'd2, 1'b0},
    '{1'b0, 4'h6, 32'h0000_BEEF, 8'h08, 1'b0, 2'd3, 2'd3, 32'h0,         1'b0, 1'b0, 4'd2, 2'd3, 1'b0},
    '{1'b0, 4'h7, 32'h0000_1111, 8'h0E, 1'b0, 2'd1, 2'd0, 32'h0,         1'b0, 1'b0, 4'd2, 2'd1, 1'b1},
    '{1'b0, 4'h5, 32'h5555_AAAA, 8'h02, 1'b0, 2'd1, 2'd3, 32'h0,         1'b1, 1'b0, 4'd0, 2'd0, 1'b0},
    '{1'b0, 4'h0, 32'hFFFF_FFFF, 8'h03, 1'b0, 2'd2, 2'd0, 32'h0,         1'b0, 1'b1, 4'd0, 2'd0, 1'b0},
    '{1'b1, 4'hE, 32'h8765_4321, 8'hFF, 1'b0, 2'd0, 2'd3, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'd8, 2'd0, 1'b1},
    '{1'b1, 4'hF, 32'h0000_0010, 8'h00, 1'b1, 2'd2, 2'd1, 32'h0000_0001, 1'b0, 1'b0, 4'd8, 2'd1, 1'b0},
    '{1'b1, 4'h5, 32'h1357_9BDF, 8'h10, 1'b0, 2'd0, 2'd0, 32'h0,         1'b1, 1'b0, 4'd0, 2'd0, 1'b0},
    '{1'b1, 4'hD, 32'h2468_ACE0, 8'h11, 1'b0, 2'd0, 2'd0, 32'h0,         1'b0, 1'b1, 4'd0, 2'd0, 1'b0},
    '{1'b0, 4'hC, 32'h0BAD_0BAD, 8'h12, 1'b1, 2'd3, 2'd1, 32'h0,         1'b0, 1'b1, 4'd0, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic issue(input vec_t v);
    @(negedge clk);
    req_long_mode     = v.lm;
    req_gate_type     = v.gtype;
    req_offset_lo     = v.off;
    req_vector        = v.vec;
    req_cs_conforming = v.conf;
    req_cs_dpl        = v.dpl;
    req_cpl           = v.cpl;
    req_valid         = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(input logic [31:0] up);
    rd_rsp_data  = {32'hA5A5_5A5A, up};
    rd_rsp_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_rsp_valid = 1'b0;
  endtask

  task automatic check_result(input vec_t v);
    logic [63:0] etgt;
    logic        ok;
    ok   = !v.e_task && !v.e_bad;
    etgt = !ok ? 64'h0 : (v.lm ? {v.upper, v.off} : {32'h0, v.off});
    chk("R1 res_valid", 64'(res_valid), 64'd1);
    chk("R2 task_switch", 64'(res_task_switch), 64'(v.e_task));
    chk("R3 bad_gate", 64'(res_bad_gate), 64'(v.e_bad));
    chk(v.lm ? "R5 push_bytes" : "R4 push_bytes", 64'(res_push_bytes), 64'(v.e_push));
    chk("R7 target", res_target, etgt);
    chk("R8 target_pl", 64'(res_target_pl), 64'(v.e_pl));
    chk("R9 pl_change", 64'(res_pl_change), 64'(v.e_chg));
  endtask

  task automatic run_vec(input vec_t v);
    issue(v);
    if (v.lm && !v.e_task && !v.e_bad) begin
      chk("R6 rd_req_valid", 64'(rd_req_valid), 64'd1);
      chk("R6 rd_addr", 64'(rd_addr), 64'({v.vec, 4'h8}));
      chk("R7 res_valid low before read", 64'(res_valid), 64'd0);
      @(posedge clk);
      @(negedge clk);
      respond(v.upper);
    end else begin
      chk("R1 no read", 64'(rd_req_valid), 64'd0);
    end
    check_result(v);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R1 idle again", 64'(req_ready), 64'd1);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset res_valid", 64'(res_valid), 64'd0);
    chk("R6 reset rd_req_valid", 64'(rd_req_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R6: stalled address channel keeps address steady
    v = TBL[6];
    v.vec = 8'h5A; v.upper = 32'h0F0F_0F0F;
    rd_req_ready = 1'b0;
    issue(v);
    repeat (2) begin
      @(negedge clk);
      chk("R6 stall valid", 64'(rd_req_valid), 64'd1);
      chk("R6 stall addr", 64'(rd_addr), 64'h5A8);
    end
    rd_req_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    respond(v.upper);
    check_result(v);

    // R10: result held under back-pressure, no new request accepted
    req_valid = 1'b1;
    req_gate_type = 4'h5;
    repeat (3) begin
      @(negedge clk);
      chk("R10 hold valid", 64'(res_valid), 64'd1);
      chk("R10 hold target", res_target, {32'h0F0F_0F0F, 32'h8765_4321});
      chk("R10 req_ready low", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk("R10 released", 64'(res_valid), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule